// File: doc/BRIEF.md
# Paged Address Translator

This block maps 16-bit virtual addresses onto a small physical memory through a 16-entry page table held in flops. The upper four address bits pick a page table entry. On a successful lookup, that entry's 3-bit frame number replaces those bits, giving a 15-bit physical address. The lower twelve bits (the byte position inside a 4 KB page) pass through unchanged. Translation is purely combinational from the access inputs. A processor-side caller presents an address, a read/write selector and a valid strobe, and in the same cycle sees either a physical address or one of two fault flags.

Each entry holds five fields: a frame number, a resident bit, read and write permission bits, and an uncached attribute. The uncached attribute is passed out beside the physical address. The block also keeps usage state for every page on its own. A successful access marks the page as used. A successful write also marks it dirty. A faulting access leaves all state alone.

A host port loads one entry per cycle, which also clears that entry's usage state. A separate one-cycle pulse wipes the used marks of all pages together. The used and dirty marks of the currently addressed page are visible on two outputs, so the host can sample them.

Top module: `vpage_xlate`

## Requirements
- R1: With `acc_valid_i` high, an access to a resident page whose permission allows it asserts `paddr_valid_o`, and `paddr_o` = {frame[2:0], acc_vaddr_i[11:0]}, where the entry is selected by acc_vaddr_i[15:12].
- R2: An access to a page whose resident bit is 0 asserts `page_fault_o` only. `paddr_valid_o`, `prot_fault_o` and `paddr_o` are 0.
- R3: An access to a resident page asserts `prot_fault_o` only, with `paddr_o` = 0, in two cases: a read while the read permission bit is 0, or a write while the write permission bit is 0.
- R4: A successful access sets that page's used mark at the next rising clock edge.
- R5: A successful write sets that page's dirty mark at the next edge. A read never changes a dirty mark.
- R6: A faulting access changes no used mark and no dirty mark.
- R7: `nocache_o` equals the entry's uncached bit during a successful access, and is 0 otherwise.
- R8: A host load (`host_we_i` high) writes frame, resident, read, write and uncached fields into entry `host_idx_i`, and clears its used and dirty marks at the next edge.
- R9: A pulse on `host_clr_ref_i` clears every used mark at the next edge and leaves dirty marks unchanged.
- R10: Same-cycle conflicts resolve as follows. A successful access in the same cycle as a `host_clr_ref_i` pulse leaves the accessed page marked used. A host load of the entry being accessed wins, so that entry's marks end at 0.
- R11: After reset every entry is non-resident with both marks at 0, so any access raises `page_fault_o`.
- R12: While `acc_valid_i` is low, `paddr_valid_o`, `page_fault_o`, `prot_fault_o`, `nocache_o` and `paddr_o` are all 0, and no mark is set. `entry_ref_o` and `entry_mod_o` always show the used and dirty marks of the page addressed by acc_vaddr_i[15:12].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | Access strobe |
| acc_write_i | input | 1 | 1 = write access, 0 = read access |
| acc_vaddr_i | input | 16 | Virtual address |
| paddr_o | output | 15 | Physical address, 0 unless the access succeeds |
| paddr_valid_o | output | 1 | Access translated successfully |
| nocache_o | output | 1 | Uncached attribute of the translated page |
| page_fault_o | output | 1 | Addressed page is not resident |
| prot_fault_o | output | 1 | Access kind not permitted on the page |
| entry_ref_o | output | 1 | Used mark of the addressed page |
| entry_mod_o | output | 1 | Dirty mark of the addressed page |
| host_we_i | input | 1 | Load one entry |
| host_idx_i | input | 4 | Entry to load |
| host_frame_i | input | 3 | Frame number to load |
| host_present_i | input | 1 | Resident bit to load |
| host_rd_ok_i | input | 1 | Read permission to load |
| host_wr_ok_i | input | 1 | Write permission to load |
| host_nocache_i | input | 1 | Uncached bit to load |
| host_clr_ref_i | input | 1 | Clear all used marks |

## Verification
The bench targets four kinds of mistake.

- Permission direction: a design that checks the wrong permission bit would translate writes to read-only pages, or fault on reads of them.
- Fault side effects: a design that updates marks on a faulting access would show a used page that was never reached.
- Same-cycle collisions: a design that lets the global clear win over a concurrent hit would lose that hit's used mark. A design that lets an access win over a host load would leave stale marks on a freshly loaded entry.
- Page boundaries: offsets 0x000 and 0xFFF on pages 0 and 15, plus a long random mix of loads, clears and accesses, expose a slipped offset or an index off by one.

// File: rtl/vpage_pkg.sv
package vpage_pkg;

  typedef struct packed {
    logic present;
    logic rd_ok;
    logic wr_ok;
    logic nocache;
  } pte_attr_t;

  typedef enum logic [1:0] {
    XL_IDLE   = 2'd0,
    XL_HIT    = 2'd1,
    XL_PFAULT = 2'd2,
    XL_PROT   = 2'd3
  } xl_status_e;

  function automatic logic access_allowed(input pte_attr_t a, input logic wr);
    return wr ? a.wr_ok : a.rd_ok;
  endfunction

endpackage

// File: rtl/vpage_table.sv
module vpage_table
  import vpage_pkg::*;
#(
  parameter int NPAGE = 16,
  parameter int IDX_W = 4,
  parameter int PFN_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [PFN_W-1:0] frame_i,
  input  pte_attr_t        attr_i,
  output logic [PFN_W-1:0] frame_o [NPAGE],
  output pte_attr_t        attr_o  [NPAGE]
);

  for (genvar g = 0; g < NPAGE; g++) begin : g_ent
    logic sel;
    assign sel = we_i && (idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        frame_o[g] <= '0;
        attr_o[g]  <= '0;
      end else if (sel) begin
        frame_o[g] <= frame_i;
        attr_o[g]  <= attr_i;
      end
    end
  end

endmodule

// File: rtl/vpage_flags.sv
module vpage_flags #(
  parameter int NPAGE = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             hit_write_i,
  input  logic [IDX_W-1:0] hit_idx_i,
  input  logic             host_we_i,
  input  logic [IDX_W-1:0] host_idx_i,
  input  logic             clr_ref_i,
  output logic [NPAGE-1:0] ref_o,
  output logic [NPAGE-1:0] mod_o
);

  for (genvar g = 0; g < NPAGE; g++) begin : g_flag
    logic hw, sel;
    assign hw  = host_we_i && (host_idx_i == IDX_W'(g));
    assign sel = hit_i && (hit_idx_i == IDX_W'(g));

    // priority: host load > access hit > global clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ref_o[g] <= 1'b0;
        mod_o[g] <= 1'b0;
      end else if (hw) begin
        ref_o[g] <= 1'b0;
        mod_o[g] <= 1'b0;
      end else begin
        if (sel)            ref_o[g] <= 1'b1;
        else if (clr_ref_i) ref_o[g] <= 1'b0;
        if (sel && hit_write_i) mod_o[g] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/vpage_lookup.sv
module vpage_lookup
  import vpage_pkg::*;
#(
  parameter int VA_W  = 16,
  parameter int VPN_W = 4,
  parameter int PFN_W = 3,
  parameter int NPAGE = 16,
  localparam int OFF_W = VA_W - VPN_W
) (
  input  logic             valid_i,
  input  logic             write_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [PFN_W-1:0] frame_tbl_i [NPAGE],
  input  pte_attr_t        attr_tbl_i  [NPAGE],
  input  logic [NPAGE-1:0] ref_i,
  input  logic [NPAGE-1:0] mod_i,
  output xl_status_e       status_o,
  output logic [VPN_W-1:0] vpn_o,
  output logic [PFN_W+OFF_W-1:0] paddr_o,
  output logic             nocache_o,
  output logic             ref_o,
  output logic             mod_o
);

  logic [VPN_W-1:0] vpn;
  logic [OFF_W-1:0] off;
  pte_attr_t        attr;
  logic [PFN_W-1:0] frame;

  assign vpn   = vaddr_i[VA_W-1 -: VPN_W];
  assign off   = vaddr_i[OFF_W-1:0];
  assign attr  = attr_tbl_i[vpn];
  assign frame = frame_tbl_i[vpn];

  always_comb begin
    status_o = XL_IDLE;
    if (valid_i) begin
      if (!attr.present)                       status_o = XL_PFAULT;
      else if (!access_allowed(attr, write_i)) status_o = XL_PROT;
      else                                     status_o = XL_HIT;
    end
  end

  assign paddr_o   = (status_o == XL_HIT) ? {frame, off} : '0;
  assign nocache_o = (status_o == XL_HIT) && attr.nocache;
  assign vpn_o     = vpn;
  assign ref_o     = ref_i[vpn];
  assign mod_o     = mod_i[vpn];

endmodule

// File: rtl/vpage_xlate.sv
module vpage_xlate
  import vpage_pkg::*;
#(
  parameter int VA_W  = 16,
  parameter int VPN_W = 4,
  parameter int PFN_W = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         acc_valid_i,
  input  logic                         acc_write_i,
  input  logic [VA_W-1:0]              acc_vaddr_i,
  output logic [PFN_W+VA_W-VPN_W-1:0]  paddr_o,
  output logic                         paddr_valid_o,
  output logic                         nocache_o,
  output logic                         page_fault_o,
  output logic                         prot_fault_o,
  output logic                         entry_ref_o,
  output logic                         entry_mod_o,
  input  logic                         host_we_i,
  input  logic [VPN_W-1:0]             host_idx_i,
  input  logic [PFN_W-1:0]             host_frame_i,
  input  logic                         host_present_i,
  input  logic                         host_rd_ok_i,
  input  logic                         host_wr_ok_i,
  input  logic                         host_nocache_i,
  input  logic                         host_clr_ref_i
);

  localparam int NPAGE = 1 << VPN_W;

  logic [PFN_W-1:0] frame_tbl [NPAGE];
  pte_attr_t        attr_tbl  [NPAGE];
  logic [NPAGE-1:0] ref_q, mod_q;
  xl_status_e       status;
  logic [VPN_W-1:0] vpn;
  pte_attr_t        host_attr;

  assign host_attr = '{present: host_present_i, rd_ok: host_rd_ok_i,
                       wr_ok: host_wr_ok_i, nocache: host_nocache_i};

  vpage_table #(.NPAGE(NPAGE), .IDX_W(VPN_W), .PFN_W(PFN_W)) table_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (host_we_i),
    .idx_i   (host_idx_i),
    .frame_i (host_frame_i),
    .attr_i  (host_attr),
    .frame_o (frame_tbl),
    .attr_o  (attr_tbl)
  );

  vpage_lookup #(.VA_W(VA_W), .VPN_W(VPN_W), .PFN_W(PFN_W), .NPAGE(NPAGE)) lookup_i (
    .valid_i     (acc_valid_i),
    .write_i     (acc_write_i),
    .vaddr_i     (acc_vaddr_i),
    .frame_tbl_i (frame_tbl),
    .attr_tbl_i  (attr_tbl),
    .ref_i       (ref_q),
    .mod_i       (mod_q),
    .status_o    (status),
    .vpn_o       (vpn),
    .paddr_o     (paddr_o),
    .nocache_o   (nocache_o),
    .ref_o       (entry_ref_o),
    .mod_o       (entry_mod_o)
  );

  vpage_flags #(.NPAGE(NPAGE), .IDX_W(VPN_W)) flags_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit_i       (status == XL_HIT),
    .hit_write_i (acc_write_i),
    .hit_idx_i   (vpn),
    .host_we_i   (host_we_i),
    .host_idx_i  (host_idx_i),
    .clr_ref_i   (host_clr_ref_i),
    .ref_o       (ref_q),
    .mod_o       (mod_q)
  );

  assign paddr_valid_o = (status == XL_HIT);
  assign page_fault_o  = (status == XL_PFAULT);
  assign prot_fault_o  = (status == XL_PROT);

endmodule

// File: rtl/vpage_xlate_chk.sv
module vpage_xlate_chk #(
  parameter int VA_W  = 16,
  parameter int VPN_W = 4,
  parameter int PFN_W = 3,
  localparam int NPAGE = 1 << VPN_W,
  localparam int OFF_W = VA_W - VPN_W
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     acc_valid_i,
  input logic                     acc_write_i,
  input logic [VA_W-1:0]          acc_vaddr_i,
  input logic [PFN_W+OFF_W-1:0]   paddr_o,
  input logic                     paddr_valid_o,
  input logic                     nocache_o,
  input logic                     page_fault_o,
  input logic                     prot_fault_o,
  input logic                     host_we_i,
  input logic [VPN_W-1:0]         host_idx_i,
  input logic                     host_clr_ref_i,
  input logic [NPAGE-1:0]         ref_vec,
  input logic [NPAGE-1:0]         mod_vec
);

  logic [VPN_W-1:0] vpn;
  logic             own_load;
  assign vpn      = acc_vaddr_i[VA_W-1 -: VPN_W];
  assign own_load = host_we_i && (host_idx_i == vpn);

  // R1
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paddr_valid_o |-> paddr_o[OFF_W-1:0] == acc_vaddr_i[OFF_W-1:0]);

  // R2
  pfault_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_fault_o |-> !paddr_valid_o && !prot_fault_o && paddr_o == '0);

  // R3
  prot_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_fault_o |-> !paddr_valid_o && paddr_o == '0 && !nocache_o);

  // R4
  ref_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paddr_valid_o && !own_load |=> ref_vec[$past(vpn)]);

  // R5
  mod_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paddr_valid_o && acc_write_i && !own_load |=> mod_vec[$past(vpn)]);

  // R6
  fault_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (page_fault_o || prot_fault_o) && !host_we_i && !host_clr_ref_i
    |=> $stable(ref_vec) && $stable(mod_vec));

  // R5
  mod_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(paddr_valid_o && acc_write_i) && !host_we_i |=> $stable(mod_vec));

  // R8
  load_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_we_i |=> !ref_vec[$past(host_idx_i)] && !mod_vec[$past(host_idx_i)]);

  // R9
  clr_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_clr_ref_i && !paddr_valid_o |=> ref_vec == '0);

  // R12
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |-> !paddr_valid_o && !page_fault_o && !prot_fault_o && !nocache_o);

endmodule

bind vpage_xlate vpage_xlate_chk #(.VA_W(VA_W), .VPN_W(VPN_W), .PFN_W(PFN_W)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .acc_valid_i    (acc_valid_i),
  .acc_write_i    (acc_write_i),
  .acc_vaddr_i    (acc_vaddr_i),
  .paddr_o        (paddr_o),
  .paddr_valid_o  (paddr_valid_o),
  .nocache_o      (nocache_o),
  .page_fault_o   (page_fault_o),
  .prot_fault_o   (prot_fault_o),
  .host_we_i      (host_we_i),
  .host_idx_i     (host_idx_i),
  .host_clr_ref_i (host_clr_ref_i),
  .ref_vec        (ref_q),
  .mod_vec        (mod_q)
);

// File: tb/vpage_xlate_tb.sv
`timescale 1ns/1ps
module vpage_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [15:0] acc_vaddr = '0;
  logic [14:0] paddr;
  logic        paddr_valid, nocache, pfault, pfault_prot, e_ref, e_mod;
  logic        host_we = 1'b0;
  logic [3:0]  host_idx = '0;
  logic [2:0]  host_frame = '0;
  logic        host_pres = 1'b0, host_rd = 1'b0, host_wr = 1'b0, host_nc = 1'b0;
  logic        host_clr = 1'b0;

  int n_chk = 0;
  int n_err = 0;

  // model: att bit3 present, bit2 read ok, bit1 write ok, bit0 uncached
  logic [2:0] m_frame [16];
  logic [3:0] m_att   [16];
  logic       m_ref   [16];
  logic       m_mod   [16];

  always #2.5 clk = ~clk;

  vpage_xlate dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_valid_i(acc_valid), .acc_write_i(acc_write), .acc_vaddr_i(acc_vaddr),
    .paddr_o(paddr), .paddr_valid_o(paddr_valid), .nocache_o(nocache),
    .page_fault_o(pfault), .prot_fault_o(pfault_prot),
    .entry_ref_o(e_ref), .entry_mod_o(e_mod),
    .host_we_i(host_we), .host_idx_i(host_idx), .host_frame_i(host_frame),
    .host_present_i(host_pres), .host_rd_ok_i(host_rd), .host_wr_ok_i(host_wr),
    .host_nocache_i(host_nc), .host_clr_ref_i(host_clr)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [14:0] exp_paddr(input logic [2:0] fr, input logic [15:0] a);
    return {fr, a[11:0]};
  endfunction

  task automatic step(input bit v, input bit w, input logic [15:0] a,
                      input bit hwe, input int hidx, input int hfr,
                      input logic [3:0] hat, input bit clr, input string ft);
    int vpn;
    bit pres, allow, hit;
    string t_o, t_r, t_m, t_n;
    @(negedge clk);
    acc_valid = v; acc_write = w; acc_vaddr = a;
    host_we = hwe; host_idx = 4'(hidx); host_frame = 3'(hfr);
    {host_pres, host_rd, host_wr, host_nc} = hat;
    host_clr = clr;
    #1;
    vpn   = int'(a[15:12]);
    pres  = m_att[vpn][3];
    allow = w ? m_att[vpn][1] : m_att[vpn][2];
    hit   = v && pres && allow;
    t_o = !v ? "R12" : (!pres ? "R2" : (!allow ? "R3" : "R1"));
    t_r = "R4"; t_m = "R5"; t_n = "R7";
    if (ft != "") begin t_o = ft; t_r = ft; t_m = ft; t_n = ft; end
    chk(t_o, "paddr_valid", int'(paddr_valid), int'(hit));
    chk(t_o, "paddr", int'(paddr), hit ? int'(exp_paddr(m_frame[vpn], a)) : 0);
    chk(t_o, "page_fault", int'(pfault), int'(v && !pres));
    chk(t_o, "prot_fault", int'(pfault_prot), int'(v && pres && !allow));
    chk(t_n, "nocache", int'(nocache), int'(hit && m_att[vpn][0]));
    chk(t_r, "entry_ref", int'(e_ref), int'(m_ref[vpn]));
    chk(t_m, "entry_mod", int'(e_mod), int'(m_mod[vpn]));
    @(posedge clk);
    for (int i = 0; i < 16; i++) begin
      if (hwe && hidx == i) begin
        m_frame[i] = 3'(hfr); m_att[i] = hat; m_ref[i] = 1'b0; m_mod[i] = 1'b0;
      end else begin
        if (hit && vpn == i) m_ref[i] = 1'b1;
        else if (clr)        m_ref[i] = 1'b0;
        if (hit && w && vpn == i) m_mod[i] = 1'b1;
      end
    end
  endtask

  task automatic acc(input bit w, input logic [15:0] a, input string ft);
    step(1, w, a, 0, 0, 0, 4'h0, 0, ft);
  endtask

  task automatic peek(input int page, input string ft);
    step(0, 0, 16'(page << 12) | 16'h0123, 0, 0, 0, 4'h0, 0, ft);
  endtask

  task automatic load(input int idx, input int fr, input logic [3:0] at);
    step(0, 0, 16'h0000, 1, idx, fr, at, 0, "R8");
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 16; i++) begin
      m_frame[i] = '0; m_att[i] = '0; m_ref[i] = 1'b0; m_mod[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R11: nothing resident after reset
    peek(0, "R11");
    acc(0, 16'h5678, "R11");
    acc(1, 16'hFFFF, "R11");

    // directed table
    load(0, 3, 4'b1110);   // rw, cached
    load(1, 7, 4'b1101);   // read-only, uncached
    load(2, 0, 4'b1010);   // write-only
    load(15, 5, 4'b1111);  // rw, uncached
    load(3, 2, 4'b0110);   // not resident

    // R1 boundaries
    acc(0, 16'h0000, "");
    acc(0, 16'h0FFF, "");
    acc(0, 16'hF000, "");
    acc(0, 16'hFFFF, "");
    // R7 uncached read of page 1
    acc(0, 16'h1ABC, "R7");
    // R5 read hit does not set dirty
    peek(1, "R5");
    // R5 write hit sets dirty
    acc(1, 16'h0ABC, "");
    peek(0, "R5");
    // R3 permission direction
    acc(1, 16'h1004, "R3");
    acc(0, 16'h2004, "R3");
    acc(1, 16'h2008, "");      // write-only page accepts write
    peek(2, "R4");
    // R6 faults leave marks untouched
    load(4, 1, 4'b1100);       // read-only, fresh marks
    acc(1, 16'h4000, "R3");
    peek(4, "R6");
    acc(0, 16'h3111, "R2");
    acc(1, 16'h3111, "R2");
    peek(3, "R6");
    // R12 idle access with a resident page
    step(0, 1, 16'hF555, 0, 0, 0, 4'h0, 0, "R12");
    peek(15, "R12");
    // R9 global clear keeps dirty marks
    step(0, 0, 16'h0000, 0, 0, 0, 4'h0, 1, "R9");
    peek(0, "R9");
    peek(1, "R9");
    peek(15, "R9");
    // R10 access during clear keeps its mark
    step(1, 0, 16'h0040, 0, 0, 0, 4'h0, 1, "R10");
    peek(0, "R10");
    peek(15, "R10");
    // R10 host load beats a write hit to the same entry
    step(1, 1, 16'hF010, 1, 15, 6, 4'b1110, 0, "R10");
    peek(15, "R10");
    acc(0, 16'hF010, "R10");
    // R8 reload clears dirty page 0
    load(0, 4, 4'b1110);
    peek(0, "R8");
    acc(0, 16'h0777, "R8");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int r = int'($urandom_range(0, 15));
      if (r == 0)
        step(0, 0, 16'(int'($urandom)), 1, int'($urandom_range(0, 15)),
             int'($urandom_range(0, 7)), 4'(int'($urandom_range(0, 15))), 0, "");
      else if (r == 1)
        step(int'($urandom_range(0, 1)) == 1, int'($urandom_range(0, 1)) == 1,
             16'(int'($urandom)), 0, 0, 0, 4'h0, 1, "");
      else
        step(r > 3, int'($urandom_range(0, 1)) == 1, 16'(int'($urandom)),
             0, 0, 0, 4'h0, 0, "");
    end

    @(negedge clk);
    acc_valid = 1'b0; host_we = 1'b0; host_clr = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule